// File: doc/BRIEF.md
# Branch Prediction Front End

This block sits beside the fetch unit and produces one prediction per accepted fetch address. It has three parts. A table of two-bit saturating counters gives the direction of conditional branches. A four-way set-associative target cache returns the target address together with the first four instructions of the target stream, so fetch can use them a cycle before the instruction cache could supply them. An eight-entry circular return stack supplies the targets of returns through the link register.

The fetch unit presents a fetch address with hints that mark the fetch as a conditional branch, a call or a return. The block accepts the fetch when `fetch_rdy_o` is high and gives a registered prediction on the next cycle. That prediction includes a return-stack checkpoint, which the fetch unit carries with the branch. When the branch resolves, the resolution port trains the counter and retires the branch. On a misprediction it also flushes, which restores the return stack from the carried checkpoint. A separate fill port writes a target-cache line after a taken branch misses the cache.

Conditional branches and returns are speculative. At most three of them may be unresolved at once. A further fetch of either kind is held off by `fetch_rdy_o` until one of them resolves.

Top module: `bpred_front`

## Requirements
- R1: After reset, every counter holds weakly-not-taken (01), so a conditional fetch predicts not taken. The target cache is empty, so `pred_hit_o` is 0. The return stack is empty. `fetch_rdy_o` is 1.
- R2: Counter encoding: 00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken. A conditional prediction takes the upper bit. A resolved conditional branch moves its counter up one step if it was taken and down one step if not, and the counter saturates at 11 and at 00. The table index is fetch-address bits [12:2], so addresses that differ only in bit 13 share a counter.
- R3: The target-cache set is address bits [6:2] and the tag is bits [31:7]. On a hit the block returns the stored target, the 128-bit instruction bundle (instruction 0 in bits [31:0]) and the 4-bit valid mask. On a miss it returns a hit flag of 0, a target of zero and a mask of zero.
- R4: A fill writes its line to a way chosen in this order: the way that already holds the same tag, else the lowest-numbered invalid way, else the way picked by the set's 3-bit tree pseudo-LRU. Lookup hits and fills both mark their way as most recently used.
- R5: A call fetch pushes the fetch address plus 4. A return fetch pops the stack, predicts taken, and gives the popped address as its target.
- R6: A push onto a full stack overwrites the oldest entry. A return that finds the stack empty predicts not taken.
- R7: When three conditional branches or returns are unresolved, a further fetch of either kind sees `fetch_rdy_o` = 0 and gets no prediction. Once one branch resolves, the held fetch is accepted. Fetches that are not speculative are not held.
- R8: A resolution with the mispredict flag set clears the unresolved-branch count to zero. It also restores the return stack to the checkpoint supplied with the resolution, taken from the `pred_ckpt_o` output of the mispredicted branch.
- R9: `pred_vld_o` is 1 exactly on the cycle after an accepted fetch. The prediction outputs are registered and valid on that cycle.
- R10: A call fetch predicts taken, with the target-cache target as its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_vld_i | input | 1 | Fetch address strobe |
| fetch_pc_i | input | 32 | Fetch address |
| fetch_cond_i | input | 1 | Hint: conditional branch |
| fetch_call_i | input | 1 | Hint: call |
| fetch_ret_i | input | 1 | Hint: return through link register |
| fetch_rdy_o | output | 1 | Fetch accepted this cycle if strobed |
| pred_vld_o | output | 1 | Prediction valid |
| pred_taken_o | output | 1 | Predicted taken |
| pred_tgt_o | output | 32 | Predicted target |
| pred_hit_o | output | 1 | Target-cache hit |
| pred_instr_o | output | 128 | Target-stream instructions |
| pred_imask_o | output | 4 | Per-instruction valid mask |
| pred_ckpt_o | output | 7 | Return-stack checkpoint for this branch |
| res_vld_i | input | 1 | A speculative branch resolves |
| res_pc_i | input | 32 | Address of the resolving branch |
| res_cond_i | input | 1 | Resolving branch is conditional (train counter) |
| res_taken_i | input | 1 | Actual direction |
| res_mispred_i | input | 1 | Mispredicted: flush |
| res_ckpt_i | input | 7 | Checkpoint to restore on flush |
| fill_vld_i | input | 1 | Target-cache fill strobe |
| fill_pc_i | input | 32 | Branch address for the fill |
| fill_tgt_i | input | 32 | Target address to store |
| fill_instr_i | input | 128 | Four target instructions |
| fill_imask_i | input | 4 | Valid mask for the four instructions |

## Verification
The hardest state to reach is the pseudo-LRU choice in a set that is already full. The bench fills four tags into one set and then reads them back in a chosen order. Each lookup moves the tree bits, so the bench can work out which way is the next victim. A fifth fill must then evict exactly that tag, and a refill of a tag that is already present must leave the victim in place. Reaching the limit on unresolved branches and the flush restore also takes planned sequences. The bench does this with runs of held conditional fetches and nested calls, and in one case a resolution arrives while a fetch is being held.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  localparam int unsigned BTC_WAYS = 4;

  typedef logic [2:0] plru_t;  // [0] root, [1] ways 0/1, [2] ways 2/3

  typedef enum logic [1:0] {
    BR_NONE,
    BR_COND,
    BR_CALL,
    BR_RET
  } br_kind_e;

  function automatic logic [1:0] plru_victim(plru_t t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  function automatic plru_t plru_touch(plru_t t, logic [1:0] w);
    plru_t n;
    n = t;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction
endpackage

// File: rtl/bpred_dir.sv
module bpred_dir #(
  parameter int unsigned ENTRIES = 2048,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [1:0]       rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  logic [1:0] ctr_q [ENTRIES];
  logic [1:0] wr_cur, wr_nxt;

  assign wr_cur = ctr_q[wr_idx_i];

  always_comb begin
    wr_nxt = wr_cur;
    if (wr_taken_i) begin
      if (wr_cur != 2'b11) wr_nxt = wr_cur + 2'b01;
    end else begin
      if (wr_cur != 2'b00) wr_nxt = wr_cur - 2'b01;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'b01;
      rd_ctr_o <= 2'b01;
    end else begin
      if (rd_en_i) rd_ctr_o <= ctr_q[rd_idx_i];
      if (wr_en_i) ctr_q[wr_idx_i] <= wr_nxt;
    end
  end

  AST_CTR_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_taken_i && wr_cur == 2'b11 && rd_en_i && rd_idx_i == wr_idx_i)
      |=> rd_ctr_o == 2'b11);  // R2
  AST_CTR_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_taken_i && wr_cur == 2'b00 && rd_en_i && rd_idx_i == wr_idx_i)
      |=> rd_ctr_o == 2'b00);  // R2
endmodule

// File: rtl/bpred_btc.sv
module bpred_btc
  import bpred_pkg::*;
#(
  parameter int unsigned SETS  = 32,
  parameter int unsigned AW    = 32,
  parameter int unsigned IW    = 32,
  parameter int unsigned NW    = 4,
  parameter int unsigned SET_W = $clog2(SETS),
  parameter int unsigned TAG_W = AW - SET_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [SET_W-1:0] rd_set_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             hit_o,
  output logic [AW-1:0]    tgt_o,
  output logic [NW*IW-1:0] instr_o,
  output logic [NW-1:0]    imask_o,
  input  logic             fill_en_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [AW-1:0]    fill_tgt_i,
  input  logic [NW*IW-1:0] fill_instr_i,
  input  logic [NW-1:0]    fill_imask_i
);
  logic [BTC_WAYS-1:0] vld_q [SETS];
  plru_t               plru_q [SETS];
  logic [TAG_W-1:0]    tag_q [SETS][BTC_WAYS];
  logic [AW-1:0]       tgt_q [SETS][BTC_WAYS];
  logic [NW*IW-1:0]    ins_q [SETS][BTC_WAYS];
  logic [NW-1:0]       msk_q [SETS][BTC_WAYS];

  logic [BTC_WAYS-1:0] rd_hit_v, fl_hit_v, fl_vld;
  logic [1:0]          rd_way, fl_way;
  logic                rd_hit;

  for (genvar w = 0; w < BTC_WAYS; w++) begin : g_way
    assign rd_hit_v[w] = vld_q[rd_set_i][w] && (tag_q[rd_set_i][w] == rd_tag_i);
    assign fl_hit_v[w] = vld_q[fill_set_i][w] && (tag_q[fill_set_i][w] == fill_tag_i);
  end

  assign rd_hit = |rd_hit_v;
  assign fl_vld = vld_q[fill_set_i];

  always_comb begin
    rd_way = 2'd0;
    for (int w = 0; w < BTC_WAYS; w++) if (rd_hit_v[w]) rd_way = 2'(w);
  end

  // Priority: same tag, then lowest invalid way, then pseudo-LRU victim.
  always_comb begin
    fl_way = plru_victim(plru_q[fill_set_i]);
    if (|fl_hit_v) begin
      for (int w = 0; w < BTC_WAYS; w++) if (fl_hit_v[w]) fl_way = 2'(w);
    end else if (!(&fl_vld)) begin
      for (int w = BTC_WAYS - 1; w >= 0; w--) if (!fl_vld[w]) fl_way = 2'(w);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
      hit_o   <= 1'b0;
      tgt_o   <= '0;
      instr_o <= '0;
      imask_o <= '0;
    end else begin
      if (rd_en_i) begin
        hit_o   <= rd_hit;
        tgt_o   <= rd_hit ? tgt_q[rd_set_i][rd_way] : '0;
        instr_o <= rd_hit ? ins_q[rd_set_i][rd_way] : '0;
        imask_o <= rd_hit ? msk_q[rd_set_i][rd_way] : '0;
        if (rd_hit) plru_q[rd_set_i] <= plru_touch(plru_q[rd_set_i], rd_way);
      end
      if (fill_en_i) begin
        vld_q[fill_set_i][fl_way] <= 1'b1;
        plru_q[fill_set_i]        <= plru_touch(plru_q[fill_set_i], fl_way);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_q[fill_set_i][fl_way] <= fill_tag_i;
      tgt_q[fill_set_i][fl_way] <= fill_tgt_i;
      ins_q[fill_set_i][fl_way] <= fill_instr_i;
      msk_q[fill_set_i][fl_way] <= fill_imask_i;
    end
  end

  AST_ONE_WAY_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_hit_v));  // R4
  AST_MISS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (imask_o == '0 && tgt_o == '0));  // R3
endmodule

// File: rtl/bpred_ras.sv
module bpred_ras #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned CKW   = PTR_W + CNT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic [AW-1:0]  push_addr_i,
  input  logic           restore_i,
  input  logic [CKW-1:0] restore_ckpt_i,
  output logic           top_vld_o,
  output logic [AW-1:0]  top_o,
  output logic [CKW-1:0] ckpt_o
);
  localparam logic [PTR_W-1:0] PTR_MAX  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [AW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_inc, ptr_dec;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign ptr_inc   = (ptr_q == PTR_MAX) ? '0 : ptr_q + 1'b1;
  assign ptr_dec   = (ptr_q == '0) ? PTR_MAX : ptr_q - 1'b1;
  assign top_vld_o = (cnt_q != '0);
  assign top_o     = mem_q[ptr_q];
  assign ckpt_o    = {cnt_d, ptr_d};

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (restore_i) begin
      {cnt_d, ptr_d} = restore_ckpt_i;
    end else if (push_i) begin
      ptr_d = ptr_inc;
      if (cnt_q != CNT_FULL) cnt_d = cnt_q + 1'b1;  // full: oldest overwritten
    end else if (pop_i && cnt_q != '0) begin
      ptr_d = ptr_dec;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !restore_i) mem_q[ptr_inc] <= push_addr_i;
  end

  AST_RAS_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !restore_i) |=> (top_vld_o && top_o == $past(push_addr_i)));  // R5
  AST_RAS_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !restore_i && !top_vld_o) |=> !top_vld_o);  // R6
  AST_RAS_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> ({cnt_q, ptr_q} == $past(restore_ckpt_i)));  // R8
endmodule

// File: rtl/bpred_front.sv
module bpred_front
  import bpred_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned IW          = 32,
  parameter int unsigned NW          = 4,
  parameter int unsigned DIR_ENTRIES = 2048,
  parameter int unsigned BTC_SETS    = 32,
  parameter int unsigned RAS_DEPTH   = 8,
  parameter int unsigned MAX_SPEC    = 3,
  parameter int unsigned RAS_CKW     = $clog2(RAS_DEPTH) + $clog2(RAS_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_vld_i,
  input  logic [AW-1:0]      fetch_pc_i,
  input  logic               fetch_cond_i,
  input  logic               fetch_call_i,
  input  logic               fetch_ret_i,
  output logic               fetch_rdy_o,
  output logic               pred_vld_o,
  output logic               pred_taken_o,
  output logic [AW-1:0]      pred_tgt_o,
  output logic               pred_hit_o,
  output logic [NW*IW-1:0]   pred_instr_o,
  output logic [NW-1:0]      pred_imask_o,
  output logic [RAS_CKW-1:0] pred_ckpt_o,
  input  logic               res_vld_i,
  input  logic [AW-1:0]      res_pc_i,
  input  logic               res_cond_i,
  input  logic               res_taken_i,
  input  logic               res_mispred_i,
  input  logic [RAS_CKW-1:0] res_ckpt_i,
  input  logic               fill_vld_i,
  input  logic [AW-1:0]      fill_pc_i,
  input  logic [AW-1:0]      fill_tgt_i,
  input  logic [NW*IW-1:0]   fill_instr_i,
  input  logic [NW-1:0]      fill_imask_i
);
  localparam int unsigned DIR_W  = $clog2(DIR_ENTRIES);
  localparam int unsigned SET_W  = $clog2(BTC_SETS);
  localparam int unsigned TAG_W  = AW - SET_W - 2;
  localparam int unsigned SPEC_W = $clog2(MAX_SPEC + 1);
  localparam logic [SPEC_W-1:0] SPEC_LIM = SPEC_W'(MAX_SPEC);

  logic               spec_hint, at_limit, flush, acc, push, pop;
  logic [SPEC_W-1:0]  spec_q, spec_d;
  br_kind_e           kind_d, kind_q;
  logic               pred_vld_q, ras_vld_q;
  logic [AW-1:0]      ras_top_q;
  logic [1:0]         dir_ctr;
  logic [AW-1:0]      btc_tgt;
  logic               ras_vld;
  logic [AW-1:0]      ras_top;
  logic [RAS_CKW-1:0] ras_ckpt;
  logic               unused_bits;

  assign unused_bits = ^{res_pc_i[AW-1:DIR_W+2], res_pc_i[1:0], fill_pc_i[1:0], dir_ctr[0]};

  assign spec_hint   = fetch_cond_i | fetch_ret_i;
  assign at_limit    = (spec_q == SPEC_LIM);
  assign flush       = res_vld_i & res_mispred_i;
  assign fetch_rdy_o = !flush && !(spec_hint && at_limit);
  assign acc         = fetch_vld_i && fetch_rdy_o;
  assign push        = acc && fetch_call_i && !fetch_ret_i;
  assign pop         = acc && fetch_ret_i;

  always_comb begin
    if (fetch_ret_i)       kind_d = BR_RET;
    else if (fetch_call_i) kind_d = BR_CALL;
    else if (fetch_cond_i) kind_d = BR_COND;
    else                   kind_d = BR_NONE;
  end

  always_comb begin
    spec_d = spec_q;
    if (flush) begin
      spec_d = '0;
    end else begin
      if (acc && spec_hint) spec_d = spec_d + 1'b1;
      if (res_vld_i && spec_d != '0) spec_d = spec_d - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spec_q      <= '0;
      pred_vld_q  <= 1'b0;
      kind_q      <= BR_NONE;
      ras_vld_q   <= 1'b0;
      ras_top_q   <= '0;
      pred_ckpt_o <= '0;
    end else begin
      spec_q     <= spec_d;
      pred_vld_q <= acc;
      if (acc) begin
        kind_q      <= kind_d;
        ras_vld_q   <= ras_vld;
        ras_top_q   <= ras_top;
        pred_ckpt_o <= ras_ckpt;
      end
    end
  end

  bpred_dir #(
    .ENTRIES(DIR_ENTRIES)
  ) u_dir (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (acc),
    .rd_idx_i  (fetch_pc_i[DIR_W+1:2]),
    .rd_ctr_o  (dir_ctr),
    .wr_en_i   (res_vld_i && res_cond_i),
    .wr_idx_i  (res_pc_i[DIR_W+1:2]),
    .wr_taken_i(res_taken_i)
  );

  bpred_btc #(
    .SETS(BTC_SETS),
    .AW  (AW),
    .IW  (IW),
    .NW  (NW)
  ) u_btc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (acc),
    .rd_set_i    (fetch_pc_i[SET_W+1:2]),
    .rd_tag_i    (fetch_pc_i[AW-1:SET_W+2]),
    .hit_o       (pred_hit_o),
    .tgt_o       (btc_tgt),
    .instr_o     (pred_instr_o),
    .imask_o     (pred_imask_o),
    .fill_en_i   (fill_vld_i),
    .fill_set_i  (fill_pc_i[SET_W+1:2]),
    .fill_tag_i  (fill_pc_i[AW-1:SET_W+2]),
    .fill_tgt_i  (fill_tgt_i),
    .fill_instr_i(fill_instr_i),
    .fill_imask_i(fill_imask_i)
  );

  bpred_ras #(
    .DEPTH(RAS_DEPTH),
    .AW   (AW),
    .CKW  (RAS_CKW)
  ) u_ras (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .push_i        (push),
    .pop_i         (pop),
    .push_addr_i   (fetch_pc_i + AW'(4)),
    .restore_i     (flush),
    .restore_ckpt_i(res_ckpt_i),
    .top_vld_o     (ras_vld),
    .top_o         (ras_top),
    .ckpt_o        (ras_ckpt)
  );

  assign pred_vld_o = pred_vld_q;

  always_comb begin
    unique case (kind_q)
      BR_COND: pred_taken_o = dir_ctr[1];
      BR_CALL: pred_taken_o = 1'b1;
      BR_RET:  pred_taken_o = ras_vld_q;
      default: pred_taken_o = 1'b0;
    endcase
  end

  assign pred_tgt_o = (kind_q == BR_RET) ? ras_top_q : btc_tgt;

  AST_SPEC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_q <= SPEC_LIM);  // R7
  AST_STALL_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_vld_i && spec_hint && at_limit) |=> !pred_vld_o);  // R7
  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> spec_q == '0);  // R8
  AST_PRED_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_vld_i && fetch_rdy_o) |=> pred_vld_o);  // R9
  AST_NO_PRED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_vld_i |=> !pred_vld_o);  // R9
endmodule

// File: tb/bpred_front_bench.sv
module bpred_front_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         fetch_vld_i, fetch_cond_i, fetch_call_i, fetch_ret_i;
  logic [31:0]  fetch_pc_i;
  logic         fetch_rdy_o, pred_vld_o, pred_taken_o, pred_hit_o;
  logic [31:0]  pred_tgt_o;
  logic [127:0] pred_instr_o;
  logic [3:0]   pred_imask_o;
  logic [6:0]   pred_ckpt_o;
  logic         res_vld_i, res_cond_i, res_taken_i, res_mispred_i;
  logic [31:0]  res_pc_i;
  logic [6:0]   res_ckpt_i;
  logic         fill_vld_i;
  logic [31:0]  fill_pc_i, fill_tgt_i;
  logic [127:0] fill_instr_i;
  logic [3:0]   fill_imask_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  bpred_front u_bpred_front (.*);

  // {train_taken, pc, expected_taken}
  localparam logic [33:0] VEC [12] = '{
    {1'b1, 32'h0000_1000, 1'b1},
    {1'b1, 32'h0000_1000, 1'b1},
    {1'b1, 32'h0000_1000, 1'b1},
    {1'b0, 32'h0000_1000, 1'b1},
    {1'b0, 32'h0000_1000, 1'b0},
    {1'b0, 32'h0000_1000, 1'b0},
    {1'b0, 32'h0000_1000, 1'b0},
    {1'b1, 32'h0000_1000, 1'b0},
    {1'b1, 32'h0000_1000, 1'b1},
    {1'b1, 32'h0000_3000, 1'b1},
    {1'b0, 32'h0000_1004, 1'b0},
    {1'b0, 32'h0000_3000, 1'b1}
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [31:0] pc, input logic c, input logic ca, input logic r);
    @(negedge clk_i);
    fetch_vld_i = 1'b1; fetch_pc_i = pc;
    fetch_cond_i = c; fetch_call_i = ca; fetch_ret_i = r;
    @(negedge clk_i);
    fetch_vld_i = 1'b0; fetch_cond_i = 1'b0; fetch_call_i = 1'b0; fetch_ret_i = 1'b0;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic c, input logic t,
                         input logic m, input logic [6:0] ck);
    @(negedge clk_i);
    res_vld_i = 1'b1; res_pc_i = pc; res_cond_i = c;
    res_taken_i = t; res_mispred_i = m; res_ckpt_i = ck;
    @(negedge clk_i);
    res_vld_i = 1'b0; res_cond_i = 1'b0; res_mispred_i = 1'b0;
  endtask

  function automatic logic [31:0] set3_pc(input int k);
    return 32'((k << 7) | (3 << 2));
  endfunction

  function automatic logic [127:0] mk_ins(input int k);
    return {32'hC000_0000 + 32'(k), 32'hB000_0000 + 32'(k),
            32'hA000_0000 + 32'(k), 32'h9000_0000 + 32'(k)};
  endfunction

  task automatic fill(input int k, input logic [31:0] tgt, input logic [3:0] msk);
    @(negedge clk_i);
    fill_vld_i = 1'b1; fill_pc_i = set3_pc(k); fill_tgt_i = tgt;
    fill_instr_i = mk_ins(k); fill_imask_i = msk;
    @(negedge clk_i);
    fill_vld_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 50000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [6:0] ck;
    rst_ni = 1'b0;
    fetch_vld_i = 0; fetch_cond_i = 0; fetch_call_i = 0; fetch_ret_i = 0; fetch_pc_i = '0;
    res_vld_i = 0; res_cond_i = 0; res_taken_i = 0; res_mispred_i = 0; res_pc_i = '0; res_ckpt_i = '0;
    fill_vld_i = 0; fill_pc_i = '0; fill_tgt_i = '0; fill_instr_i = '0; fill_imask_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    check("R1 rdy", 128'(fetch_rdy_o), 128'(1));
    check("R1 vld", 128'(pred_vld_o), 128'(0));
    do_fetch(32'h1000, 1, 0, 0);
    check("R9 vld after fetch", 128'(pred_vld_o), 128'(1));
    check("R1 cond not taken", 128'(pred_taken_o), 128'(0));
    check("R1 no hit", 128'(pred_hit_o), 128'(0));
    @(negedge clk_i);
    check("R9 vld drops", 128'(pred_vld_o), 128'(0));
    do_fetch(32'h2000, 0, 0, 1);
    check("R6 empty pop not taken", 128'(pred_taken_o), 128'(0));
    resolve(32'h0, 0, 0, 1, 7'd0);

    // R2 counter table
    for (int i = 0; i < 12; i++) begin
      resolve(VEC[i][32:1], 1'b1, VEC[i][33], 1'b0, 7'd0);
      do_fetch(VEC[i][32:1], 1, 0, 0);
      check($sformatf("R2 vec %0d", i), 128'(pred_taken_o), 128'(VEC[i][0]));
    end
    resolve(32'h0, 0, 0, 1, 7'd0);

    // R3 / R4 target cache
    for (int k = 1; k <= 4; k++)
      fill(k, 32'h8000_0000 + 32'(k * 16), (k == 2) ? 4'b0111 : 4'b1111);
    do_fetch(set3_pc(2), 0, 0, 0);
    check("R3 hit", 128'(pred_hit_o), 128'(1));
    check("R3 tgt", 128'(pred_tgt_o), 128'(32'h8000_0020));
    check("R3 instr", pred_instr_o, mk_ins(2));
    check("R3 mask", 128'(pred_imask_o), 128'(4'b0111));
    do_fetch(set3_pc(9), 0, 0, 0);
    check("R3 miss hit", 128'(pred_hit_o), 128'(0));
    check("R3 miss mask", 128'(pred_imask_o), 128'(0));
    check("R3 miss tgt", 128'(pred_tgt_o), 128'(0));
    fill(5, 32'h8000_0050, 4'b1111);
    do_fetch(set3_pc(3), 0, 0, 0);
    check("R4 plru victim evicted", 128'(pred_hit_o), 128'(0));
    for (int k = 1; k <= 5; k++) begin
      if (k != 3) begin
        do_fetch(set3_pc(k), 0, 0, 0);
        check($sformatf("R4 kept tag %0d", k), 128'(pred_hit_o), 128'(1));
      end
    end
    fill(2, 32'h8000_0F00, 4'b1111);
    do_fetch(set3_pc(1), 0, 0, 0);
    check("R4 refill in place keeps lru way", 128'(pred_hit_o), 128'(1));
    do_fetch(set3_pc(2), 0, 0, 0);
    check("R4 refill new tgt", 128'(pred_tgt_o), 128'(32'h8000_0F00));

    // R10 / R5 call and return
    do_fetch(set3_pc(4), 0, 1, 0);
    check("R10 call taken", 128'(pred_taken_o), 128'(1));
    check("R10 call tgt", 128'(pred_tgt_o), 128'(32'h8000_0040));
    do_fetch(32'h5000, 0, 0, 1);
    check("R5 ret taken", 128'(pred_taken_o), 128'(1));
    check("R5 ret tgt", 128'(pred_tgt_o), 128'(set3_pc(4) + 32'd4));
    resolve(32'h0, 0, 0, 0, 7'd0);

    // R6 overflow
    for (int i = 1; i <= 9; i++) do_fetch(32'h0001_0000 + 32'(i * 256), 0, 1, 0);
    for (int j = 0; j < 8; j++) begin
      do_fetch(32'h6000, 0, 0, 1);
      check($sformatf("R6 pop %0d taken", j), 128'(pred_taken_o), 128'(1));
      check($sformatf("R6 pop %0d tgt", j), 128'(pred_tgt_o),
            128'(32'h0001_0000 + 32'((9 - j) * 256) + 32'd4));
      resolve(32'h0, 0, 0, 0, 7'd0);
    end
    do_fetch(32'h6000, 0, 0, 1);
    check("R6 oldest lost, empty", 128'(pred_taken_o), 128'(0));
    resolve(32'h0, 0, 0, 0, 7'd0);

    // R7 limit
    for (int i = 0; i < 3; i++) begin
      do_fetch(32'h1000, 1, 0, 0);
      check("R7 accepted below limit", 128'(pred_vld_o), 128'(1));
    end
    @(negedge clk_i);
    fetch_vld_i = 1; fetch_pc_i = 32'h1000; fetch_cond_i = 1;
    #1 check("R7 rdy low at limit", 128'(fetch_rdy_o), 128'(0));
    fetch_cond_i = 0;
    #1 check("R7 non-branch not held", 128'(fetch_rdy_o), 128'(1));
    fetch_cond_i = 1;
    @(negedge clk_i);
    check("R7 no prediction", 128'(pred_vld_o), 128'(0));
    res_vld_i = 1;
    @(negedge clk_i);
    res_vld_i = 0;
    #1 check("R7 rdy after resolve", 128'(fetch_rdy_o), 128'(1));
    @(negedge clk_i);
    check("R7 held fetch accepted", 128'(pred_vld_o), 128'(1));
    fetch_vld_i = 0; fetch_cond_i = 0;

    // R8 flush restore
    do_fetch(32'h7000, 0, 1, 0);
    ck = pred_ckpt_o;
    do_fetch(32'h7100, 0, 1, 0);
    do_fetch(32'h7200, 0, 1, 0);
    resolve(32'h0, 0, 0, 1, ck);
    do_fetch(32'h7800, 0, 0, 1);
    check("R8 ret vld", 128'(pred_vld_o), 128'(1));
    check("R8 restored tgt", 128'(pred_tgt_o), 128'(32'h7004));
    for (int i = 0; i < 2; i++) begin
      do_fetch(32'h1000, 1, 0, 0);
      check("R8 count cleared", 128'(pred_vld_o), 128'(1));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule